// File: doc/BRIEF.md
# Instruction Buffer with Shared Region Register

This block is the per-thread queue between instruction fetch and decode. Fetch presents groups of up to four consecutive instructions, together with the byte address of the first one. Decode takes one instruction per cycle from an output register, called the decode latch, through a valid/ready handshake. Instructions come out in program order.

Three storage levels hold instructions, from oldest to youngest. The decode latch comes first. The step-aside register comes next and holds one instruction that arrived while the decode latch was occupied. The eight-entry ring is last. To keep the ring small, each ring entry keeps only 22 bits of its word address. One shared register supplies the upper bits, which mark the 16 MB region, for every ring entry. A group from a different region cannot enter while the ring still holds instructions. The block drops such a group and raises a refetch request in the same cycle. Fetch retries the group, and it is accepted once the ring has drained. When nothing is waiting ahead of it, an accepted group's first instruction goes straight into the decode latch.

Top module: `ibuf_top`

## Requirements
- R1: After reset, `dec_valid_o` and `fg_refetch_o` are low.
- R2: Instructions reach the decode latch in arrival order of their groups. Within a group, they come out in ascending address order at 4-byte steps (instruction k has address `fg_addr_i + 4*k`, and its data is `fg_instr_i[32*k +: 32]`).
- R3: The ring holds 8 instructions. A group is accepted only if the ring count plus `fg_count_i` is at most 8. Otherwise it is dropped and `fg_refetch_o` is high in that same cycle.
- R4: If a group's region (address bits 31:24) differs from the shared region register while the ring is not empty, the group is dropped and `fg_refetch_o` is high in that same cycle.
- R5: The shared region register takes a new value only in a cycle where the ring is empty, and it takes it from the accepted group.
- R6: When the ring and the step-aside register are empty and the decode latch is empty or being read, the first instruction of an accepted group is in the decode latch after the next clock edge.
- R7: When the decode latch is held and the ring is empty, the next incoming instruction is captured in the step-aside register. It reaches the decode latch right after the current one.
- R8: An instruction read from the ring is presented with the address {shared region, stored 22 bits, 2'b00}.
- R9: `flush_i` empties the decode latch, the step-aside register and the ring in one cycle. A group presented together with the flush is discarded without a refetch request.
- R10: While `dec_valid_o` is high and `dec_ready_i` is low, the decode latch keeps its address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard every held instruction |
| fg_valid_i | input | 1 | A fetch group is presented |
| fg_count_i | input | 3 | Number of instructions in the group (1 to 4) |
| fg_addr_i | input | 32 | Byte address of the group's first instruction |
| fg_instr_i | input | 128 | Instruction words, slot k at bits 32k+31:32k |
| fg_refetch_o | output | 1 | Presented group was dropped and must be fetched again |
| dec_valid_o | output | 1 | Decode latch holds an instruction |
| dec_addr_o | output | 32 | Address of the instruction in the decode latch |
| dec_instr_o | output | 32 | Instruction in the decode latch |
| dec_ready_i | input | 1 | Decode takes the latched instruction this cycle |

## Verification
Two events can fall in the same cycle. A read from the ring hands its oldest entry to decode, and a group from another region is rejected. The bench provokes this by presenting a foreign-region group while `dec_ready_i` is high and the ring still holds entries. It then checks two things. The refetch request must rise in that cycle, and the decode latch must advance to exactly the next expected address, with no trace of the rejected group. A second case has the bypass and the step-aside capture in the same edge. A four-instruction group lands in an empty buffer while decode is stalled. The bench checks the whole drain order that follows.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    localparam int ADDR_W   = 32;
    localparam int INSTR_W  = 32;
    localparam int ALIGN_W  = 2;
    localparam int LOW_W    = 22;
    localparam int REGION_W = ADDR_W - LOW_W - ALIGN_W;

    // instruction with its full address (decode latch, step-aside register)
    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [ADDR_W-1:0]  addr;
    } slot_t;

    // compressed ring entry: only the word address below the region boundary
    typedef struct packed {
        logic [INSTR_W-1:0] instr;
        logic [LOW_W-1:0]   low;
    } entry_t;
endpackage

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 8,          // power of two
    parameter int GROUP = 4,
    localparam int NUM_W = $clog2(GROUP + 1),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_i,
    input  logic [NUM_W-1:0]      wr_num_i,
    input  entry_t [GROUP-1:0]    wr_data_i,
    input  logic                  pop_i,
    output entry_t                head_o,
    output logic [CNT_W-1:0]      count_o
);
    localparam int PTR_W = $clog2(DEPTH);

    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [CNT_W-1:0]   cnt;
    } store_t;

    store_t s_d, s_q;
    logic [PTR_W-1:0] wr_base;

    always_comb begin
        s_d     = s_q;
        wr_base = s_q.rd + PTR_W'(s_q.cnt);
        for (int j = 0; j < GROUP; j++) begin
            if (j < int'(wr_num_i)) begin
                s_d.mem[wr_base + PTR_W'(j)] = wr_data_i[j];
            end
        end
        if (pop_i) begin
            s_d.rd = s_q.rd + PTR_W'(1);
        end
        s_d.cnt = s_q.cnt + CNT_W'(wr_num_i) - CNT_W'(pop_i);
        if (flush_i) begin
            s_d.rd  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rd];
    assign count_o = s_q.cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |-> (int'(s_q.cnt) + int'(wr_num_i) - int'(pop_i) <= DEPTH));

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |-> (s_q.cnt != '0));
endmodule

// File: rtl/ibuf_region.sv
module ibuf_region
    import ibuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [REGION_W-1:0] region_i,
    input  logic                store_empty_i,
    output logic [REGION_W-1:0] region_o,
    output logic                conflict_o
);
    typedef struct packed {
        logic [REGION_W-1:0] region;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) r_d.region = region_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign region_o   = r_q.region;
    assign conflict_o = !store_empty_i && (region_i != r_q.region);

    assert_region_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !store_empty_i |=> $stable(r_q.region));
endmodule

// File: rtl/ibuf_top.sv
module ibuf_top
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int GROUP = 4,
    localparam int NUM_W = $clog2(GROUP + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush_i,
    input  logic                       fg_valid_i,
    input  logic [NUM_W-1:0]           fg_count_i,
    input  logic [ADDR_W-1:0]          fg_addr_i,
    input  logic [GROUP*INSTR_W-1:0]   fg_instr_i,
    output logic                       fg_refetch_o,
    output logic                       dec_valid_o,
    output logic [ADDR_W-1:0]          dec_addr_o,
    output logic [INSTR_W-1:0]         dec_instr_o,
    input  logic                       dec_ready_i
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (GROUP > 1) ? $clog2(GROUP) : 1;

    typedef struct packed {
        logic  d_v;   // decode latch
        slot_t d;
        logic  s_v;   // step-aside register
        slot_t s;
    } front_t;

    front_t cur_q, nxt_d;

    slot_t                inc [GROUP];
    entry_t [GROUP-1:0]   wr_data;
    logic [NUM_W-1:0]     wr_num;
    logic                 pop;
    entry_t               head;
    slot_t                head_slot;
    logic [CNT_W-1:0]     fifo_cnt;
    logic                 fifo_empty;
    logic [REGION_W-1:0]  region_q;
    logic                 region_conflict;
    logic                 region_load;
    logic                 room;
    logic                 accept;
    logic                 f_empty_after;
    int                   nin;
    int                   take;

    // expand the fetch group into per-slot instructions with full addresses
    for (genvar k = 0; k < GROUP; k++) begin : g_slot
        assign inc[k].instr = fg_instr_i[k*INSTR_W +: INSTR_W];
        assign inc[k].addr  = fg_addr_i + (ADDR_W'(k) << ALIGN_W);
    end

    assign fifo_empty      = (fifo_cnt == '0);
    assign head_slot.instr = head.instr;
    assign head_slot.addr  = {region_q, head.low, {ALIGN_W{1'b0}}};

    assign room         = (int'(fifo_cnt) + int'(fg_count_i)) <= DEPTH;
    assign accept       = fg_valid_i && !flush_i && !region_conflict && room;
    assign fg_refetch_o = fg_valid_i && !flush_i && !accept;
    assign region_load  = accept && fifo_empty;

    always_comb begin
        nxt_d = cur_q;
        pop   = 1'b0;
        take  = 0;
        nin   = 0;
        if (accept) nin = (int'(fg_count_i) > GROUP) ? GROUP : int'(fg_count_i);

        // decode latch refill: step-aside, then ring head, then bypass
        if (!cur_q.d_v || dec_ready_i) begin
            if (cur_q.s_v) begin
                nxt_d.d   = cur_q.s;
                nxt_d.d_v = 1'b1;
                nxt_d.s_v = 1'b0;
            end else if (!fifo_empty) begin
                nxt_d.d   = head_slot;
                nxt_d.d_v = 1'b1;
                pop       = 1'b1;
            end else if (nin > 0) begin
                nxt_d.d   = inc[0];
                nxt_d.d_v = 1'b1;
                take      = 1;
            end else begin
                nxt_d.d_v = 1'b0;
            end
        end

        // step-aside capture only while nothing older waits in the ring
        f_empty_after = fifo_empty || ((fifo_cnt == CNT_W'(1)) && pop);
        if (!nxt_d.s_v && f_empty_after && (nin > take)) begin
            nxt_d.s   = inc[IDX_W'(take)];
            nxt_d.s_v = 1'b1;
            take      = take + 1;
        end

        // remaining instructions go to the ring, compacted from slot 0
        for (int j = 0; j < GROUP; j++) begin
            wr_data[j] = '0;
            if (j + take < GROUP) begin
                wr_data[j].instr = inc[IDX_W'(j + take)].instr;
                wr_data[j].low   = inc[IDX_W'(j + take)].addr[LOW_W+ALIGN_W-1:ALIGN_W];
            end
        end
        wr_num = NUM_W'(nin - take);

        if (flush_i) begin
            nxt_d = '0;
            pop   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dec_valid_o = cur_q.d_v;
    assign dec_addr_o  = cur_q.d.addr;
    assign dec_instr_o = cur_q.d.instr;

    ibuf_store #(.DEPTH(DEPTH), .GROUP(GROUP)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .wr_num_i  (wr_num),
        .wr_data_i (wr_data),
        .pop_i     (pop),
        .head_o    (head),
        .count_o   (fifo_cnt)
    );

    ibuf_region u_region (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (region_load),
        .region_i      (fg_addr_i[ADDR_W-1:LOW_W+ALIGN_W]),
        .store_empty_i (fifo_empty),
        .region_o      (region_q),
        .conflict_o    (region_conflict)
    );

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && !dec_ready_i && !flush_i) |=>
        (dec_valid_o && $stable(dec_addr_o) && $stable(dec_instr_o)));

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !dec_valid_o);

    assert_conflict_refetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fg_valid_i && !flush_i && region_conflict) |-> fg_refetch_o);

    assert_steps_aside_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.s_v && !flush_i) |-> cur_q.d_v);
endmodule

// File: tb/tb_ibuf_top.sv
module tb_ibuf_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush_i = 1'b0;
    logic         fg_valid_i = 1'b0;
    logic [2:0]   fg_count_i = '0;
    logic [31:0]  fg_addr_i = '0;
    logic [127:0] fg_instr_i = '0;
    logic         fg_refetch_o;
    logic         dec_valid_o;
    logic [31:0]  dec_addr_o;
    logic [31:0]  dec_instr_o;
    logic         dec_ready_i = 1'b0;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibuf_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .fg_valid_i   (fg_valid_i),
        .fg_count_i   (fg_count_i),
        .fg_addr_i    (fg_addr_i),
        .fg_instr_i   (fg_instr_i),
        .fg_refetch_o (fg_refetch_o),
        .dec_valid_o  (dec_valid_o),
        .dec_addr_o   (dec_addr_o),
        .dec_instr_o  (dec_instr_o),
        .dec_ready_i  (dec_ready_i)
    );

    typedef struct packed {
        logic        v;
        logic [2:0]  n;
        logic [31:0] a;
        logic        rdy;
        logic        erf;
        logic        edv;
        logic [31:0] ea;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd4, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 32'h0000_1000}, // bypass + step-aside
        '{1'b1, 3'd4, 32'h0000_1010, 1'b0, 1'b0, 1'b1, 32'h0000_1000},
        '{1'b1, 3'd2, 32'h0100_0000, 1'b0, 1'b1, 1'b1, 32'h0000_1000}, // region conflict
        '{1'b1, 3'd4, 32'h0000_1020, 1'b0, 1'b1, 1'b1, 32'h0000_1000}, // no room
        '{1'b1, 3'd2, 32'h0000_1020, 1'b0, 1'b0, 1'b1, 32'h0000_1000}, // fills to 8
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1004},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1008},
        '{1'b1, 3'd2, 32'h0100_0000, 1'b1, 1'b1, 1'b1, 32'h0000_100C}, // pop + conflict
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1010},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1014},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1018},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_101C},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1020},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0000_1024},
        '{1'b1, 3'd2, 32'h0100_0000, 1'b1, 1'b0, 1'b1, 32'h0100_0000}, // region switch
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0100_0004},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0},
        '{1'b1, 3'd4, 32'h0100_0010, 1'b0, 1'b0, 1'b1, 32'h0100_0010},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0100_0014},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0100_0018}, // ring, new region
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b1, 32'h0100_001C},
        '{1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b0, 32'h0}
    };

    task automatic check_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    // called at a falling edge; drives, checks refetch, then checks the latch one edge later
    task automatic step(input logic v, input logic [2:0] n, input logic [31:0] a,
                        input logic rdy, input logic fl, input logic erf,
                        input logic edv, input logic [31:0] ea, input string tag);
        fg_valid_i  = v;
        fg_count_i  = n;
        fg_addr_i   = a;
        dec_ready_i = rdy;
        flush_i     = fl;
        for (int k = 0; k < 4; k++) fg_instr_i[k*32 +: 32] = ~(a + 32'(4*k));
        #1;
        check_bit({tag, " refetch"}, fg_refetch_o, erf);
        @(negedge clk);
        check_bit({tag, " dec_valid"}, dec_valid_o, edv);
        if (edv) begin
            check_word({tag, " dec_addr"}, dec_addr_o, ea);
            check_word({tag, " dec_instr"}, dec_instr_o, ~ea);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_bit("R1 reset dec_valid", dec_valid_o, 1'b0);
        check_bit("R1 reset refetch", fg_refetch_o, 1'b0);

        // table walk: R2 order, R3 capacity, R4 conflict, R5 region switch, R8 address, R10 hold
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].v, VEC[i].n, VEC[i].a, VEC[i].rdy, 1'b0,
                 VEC[i].erf, VEC[i].edv, VEC[i].ea, "R2 R3 R4 R5 R8 R10 table");
        end

        // R9: flush with a group present empties everything, no refetch request
        step(1'b1, 3'd4, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_2000, "R6 fill");
        step(1'b1, 3'd4, 32'h0000_2010, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         "R9 flush");
        // R9: a foreign region is accepted at once only if the ring really was cleared
        step(1'b1, 3'd1, 32'h0500_0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0500_0000, "R9 R6 after flush");
        // R7: decode latch held, ring empty: next instruction goes to the step-aside register
        step(1'b1, 3'd1, 32'h0500_0004, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0500_0000, "R7 capture");
        step(1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b1, 32'h0500_0004, "R7 release");
        step(1'b0, 3'd0, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         "R9 drained");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule